// File: doc/BRIEF.md
# Queued SPI Master with Command RAM

This block is an SPI bus master that works through a short queue of byte transfers on its own. Software uses a 32-bit register bus to fill up to sixteen queue entries. Each entry holds a command byte, a transmit byte and a slot for the received byte. Software then sets a first and a last queue index and writes the go bit. The block shifts each entry in turn. For every entry it drives the four active-low chip-selects from that entry's command byte. When the last entry has finished, it raises a done flag.

Two options let a long bus transaction span many entries and many runs. With the keep-select bit set in a command byte, the select lines stay asserted from that entry into the next one. With the hold bit set in the control register, the select lines stay asserted after the final entry of a run, so the next run continues the same transaction. A separate lock register lets software mark such a transaction as open. While a run is in progress, the queue contents and the first and last indices are protected from bus writes.

Register map (byte offsets):
- 0x210: first index
- 0x214: last index
- 0x218: control (bit 6 go, bit 7 hold)
- 0x220: status (bit 0 done)
- 0x224: current index
- 0x240 + 8*i: transmit byte of entry i
- 0x2c0 + 8*i + 4: received byte of entry i
- 0x340 + 4*i: command byte of entry i
- 0x380: lock

Top module: `qspi_master`

## Requirements
- R1: After reset, all four chip-selects are high and SCK is low, and the control, status and current-index registers read 0.
- R2: Each entry sends its transmit byte, written at word 2*i of the transmit area (byte offset 0x240+8*i), most significant bit first in SPI mode 0. SCK idles low, MOSI does not change while SCK is high, and each entry gives exactly 8 SCK pulses.
- R3: The byte sampled on MISO for entry i can be read at word 2*i+1 of the receive area (byte offset 0x2c0+8*i+4).
- R4: A run shifts the entries from the first index up to and including the last index. The index wraps from 15 to 0.
- R5: While an entry is shifting, chip-select line k is driven low exactly when bit k (k = 0..3) of that entry's command byte is 0.
- R6: If command bit 7 of an entry is 1, the selects go straight into the next entry with no high gap. If it is 0 and more entries follow, all selects go high for at least HALF_DIV system clocks before the next entry.
- R7: At the end of a run, all selects go high, unless command bit 7 of the last entry is 1 or control bit 7 (hold) is 1. In either of those cases the last entry's select levels are kept.
- R8: Writing 1 to control bit 6 starts a run, and bit 6 reads 1 until the run ends. At the end of a run, status bit 0 goes to 1. A status write with bit 0 = 0 clears it, and a status write with bit 0 = 1 leaves it unchanged.
- R9: The first rising SCK edge of an entry comes HALF_DIV+1 system clocks after its selects assert. If command bit 4 is set, it comes DELAY_HALVES*HALF_DIV clocks later than that.
- R10: During a run, the current-index register reads only indices that belong to the run.
- R11: While a run is in progress, writes to the transmit and command areas and to the first and last indices have no effect.
- R12: Bit 0 of the lock register can be read and written at any time.
- R13: The SCK period is 2*HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip-selects |

## Verification
The bench models an SPI slave that collects every byte sent on MOSI. With each byte it records the select levels, whether the selects went high since the previous byte, and the delay from select assertion to the first clock edge. It answers each byte with a response that depends on the byte's position in the test.

The tests cover four run shapes:
- A single entry, which separates the per-entry select decoding from any chaining.
- A chained three-entry run, which shows that the keep-select bit suppresses the gap.
- A two-entry run without that bit, which shows that the gap appears.
- A run that wraps from index 15 to index 0, which separates inclusive end handling from a plain increment.

Further single-entry runs with the hold bit, with a held last entry and with the delay bit separate the end-of-run select rules and the start delay. A run with writes issued in mid-flight shows that the queue is protected.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
    // Queue geometry is fixed by the register map.
    localparam int unsigned QDEPTH = 16;
    localparam int unsigned NSEL   = 4;

    // Word indices (byte offset / 4) of the register map.
    localparam logic [7:0] WI_FIRST = 8'h84;
    localparam logic [7:0] WI_LAST  = 8'h85;
    localparam logic [7:0] WI_CTRL  = 8'h86;
    localparam logic [7:0] WI_STAT  = 8'h88;
    localparam logic [7:0] WI_CUR   = 8'h89;
    localparam logic [7:0] WI_TX    = 8'h90;
    localparam logic [7:0] WI_RX    = 8'hB0;
    localparam logic [7:0] WI_CMD   = 8'hD0;
    localparam logic [7:0] WI_CEND  = 8'hE0;
    localparam logic [7:0] WI_LOCK  = 8'hE0;

    // Command byte fields.
    localparam int unsigned CB_DLY  = 4;
    localparam int unsigned CB_KEEP = 7;

    // Control register fields.
    localparam int unsigned CR_GO   = 6;
    localparam int unsigned CR_HOLD = 7;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WAIT,
        SQ_GAP
    } seq_e;
endpackage

// File: rtl/qspi_tick.sv
module qspi_tick #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == CW'(HALF_DIV - 1));

    always_comb begin
        if (!en || tick) cnt_d = '0;
        else             cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
    parameter int unsigned DELAY_HALVES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       dly,
    input  logic       tick,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi
);
    localparam int unsigned LW = (DELAY_HALVES > 0) ? $clog2(DELAY_HALVES + 1) : 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          sck;
        logic          mosi;
        logic [7:0]    txs;
        logic [7:0]    rxs;
        logic [3:0]    hc;
        logic [LW-1:0] lead;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (go) begin
                d.busy = 1'b1;
                d.txs  = tx_byte;
                d.mosi = tx_byte[7];
                d.sck  = 1'b0;
                d.hc   = '0;
                d.lead = dly ? LW'(DELAY_HALVES) : '0;
            end
        end else if (tick) begin
            if (q.lead != '0) begin
                d.lead = q.lead - LW'(1);
            end else if (!q.hc[0]) begin
                // leading edge: sample
                d.sck = 1'b1;
                d.rxs = {q.rxs[6:0], miso};
                d.hc  = q.hc + 4'd1;
            end else begin
                // trailing edge: next bit or finish
                d.sck = 1'b0;
                d.hc  = q.hc + 4'd1;
                if (q.hc == 4'hF) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.mosi = 1'b0;
                end else begin
                    d.txs  = {q.txs[6:0], 1'b0};
                    d.mosi = q.txs[6];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign rx_byte = q.rxs;
    assign sck     = q.sck;
    assign mosi    = q.mosi;
endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
#(
    parameter int unsigned HALF_DIV     = 4,
    parameter int unsigned DELAY_HALVES = 2,
    parameter int unsigned ADDR_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NSEL-1:0]   spi_cs_n
);
    localparam int unsigned GW = $clog2(HALF_DIV + 1);
    localparam int unsigned IW = $clog2(QDEPTH);

    typedef struct packed {
        logic [IW-1:0]                first;
        logic [IW-1:0]                last;
        logic [IW-1:0]                ptr;
        logic                         run;
        logic                         hold;
        logic                         fin;
        logic                         lock;
        logic                         go;
        seq_e                         st;
        logic [NSEL-1:0]              cs_n;
        logic [GW-1:0]                gap;
        logic [QDEPTH-1:0][7:0]       tx;
        logic [QDEPTH-1:0][7:0]       rx;
        logic [QDEPTH-1:0][7:0]       cmd;
    } st_t;

    st_t d, q;

    logic       tick, sh_busy, sh_done;
    logic [7:0] sh_rx;
    logic [7:0] widx, toff, roff;
    logic       in_tx, in_rx, in_cmd, wr_en;
    logic       unused_bits;

    // Register decode
    assign widx   = 8'(bus_addr >> 2);
    assign toff   = widx - WI_TX;
    assign roff   = widx - WI_RX;
    assign in_tx  = (widx >= WI_TX)  && (widx < WI_RX);
    assign in_rx  = (widx >= WI_RX)  && (widx < WI_CMD);
    assign in_cmd = (widx >= WI_CMD) && (widx < WI_CEND);
    assign wr_en  = bus_sel && bus_wr;
    assign unused_bits = ^{bus_wdata[31:8]};

    always_comb begin
        d    = q;
        d.go = 1'b0;

        // Bus writes
        if (wr_en) begin
            if (widx == WI_FIRST && !q.run) d.first = bus_wdata[IW-1:0];
            if (widx == WI_LAST  && !q.run) d.last  = bus_wdata[IW-1:0];
            if (widx == WI_CTRL  && !q.run) begin
                d.hold = bus_wdata[CR_HOLD];
                if (bus_wdata[CR_GO]) begin
                    d.run = 1'b1;
                    d.ptr = q.first;
                    d.st  = SQ_LOAD;
                end
            end
            if (widx == WI_STAT && !bus_wdata[0]) d.fin  = 1'b0;
            if (widx == WI_LOCK)                  d.lock = bus_wdata[0];
            if (in_tx && !toff[0] && !q.run)      d.tx[toff[4:1]] = bus_wdata[7:0];
            if (in_cmd && !q.run)                 d.cmd[widx[3:0]] = bus_wdata[7:0];
        end

        // Queue sequencer
        unique case (q.st)
            SQ_LOAD: begin
                d.cs_n = q.cmd[q.ptr][NSEL-1:0];
                d.go   = 1'b1;
                d.st   = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (sh_done) begin
                    d.rx[q.ptr] = sh_rx;
                    if (q.ptr == q.last) begin
                        d.run = 1'b0;
                        d.fin = 1'b1;
                        d.st  = SQ_IDLE;
                        if (!q.cmd[q.ptr][CB_KEEP] && !q.hold) d.cs_n = '1;
                    end else begin
                        d.ptr = q.ptr + IW'(1);
                        if (q.cmd[q.ptr][CB_KEEP]) begin
                            d.st = SQ_LOAD;
                        end else begin
                            d.cs_n = '1;
                            d.gap  = GW'(HALF_DIV);
                            d.st   = SQ_GAP;
                        end
                    end
                end
            end
            SQ_GAP: begin
                d.gap = q.gap - GW'(1);
                if (q.gap <= GW'(1)) d.st = SQ_LOAD;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= '1;
        end else begin
            q <= d;
        end
    end

    // Register read
    always_comb begin
        bus_rdata = '0;
        if (widx == WI_FIRST)     bus_rdata[IW-1:0] = q.first;
        else if (widx == WI_LAST) bus_rdata[IW-1:0] = q.last;
        else if (widx == WI_CTRL) begin
            bus_rdata[CR_GO]   = q.run;
            bus_rdata[CR_HOLD] = q.hold;
        end
        else if (widx == WI_STAT) bus_rdata[0] = q.fin;
        else if (widx == WI_CUR)  bus_rdata[IW-1:0] = q.ptr;
        else if (widx == WI_LOCK) bus_rdata[0] = q.lock;
        else if (in_tx && !toff[0]) bus_rdata[7:0] = q.tx[toff[4:1]];
        else if (in_rx && roff[0])  bus_rdata[7:0] = q.rx[roff[4:1]];
        else if (in_cmd)            bus_rdata[7:0] = q.cmd[widx[3:0]];
    end

    qspi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (sh_busy),
        .tick (tick)
    );

    qspi_shift #(.DELAY_HALVES(DELAY_HALVES)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (q.go),
        .tx_byte(q.tx[q.ptr]),
        .dly    (q.cmd[q.ptr][CB_DLY]),
        .tick   (tick),
        .miso   (spi_miso),
        .busy   (sh_busy),
        .done   (sh_done),
        .rx_byte(sh_rx),
        .sck    (spi_sck),
        .mosi   (spi_mosi)
    );

    assign spi_cs_n = q.cs_n;

    // Plain views for the bound checker
    logic          run_busy, done_flag;
    logic [IW-1:0] cur_ptr, first_ptr, last_ptr;
    assign run_busy  = q.run;
    assign done_flag = q.fin;
    assign cur_ptr   = q.ptr;
    assign first_ptr = q.first;
    assign last_ptr  = q.last;
endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sck,
    input logic       mosi,
    input logic       run_busy,
    input logic       done_flag,
    input logic [3:0] cur_ptr,
    input logic [3:0] first_ptr,
    input logic [3:0] last_ptr
);
    // R2: no clocking outside a run
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_busy |-> !sck);

    // R2: mode 0, data held while the clock is high
    p_mosi_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R8: end of run raises the done flag
    p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_busy) |-> done_flag);

    // R4: index advances by one (mod 16) within a run
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_busy && $past(run_busy) && !$stable(cur_ptr))
            |-> cur_ptr == $past(cur_ptr) + 4'd1);

    // R4: run ends on the last index
    p_end_ptr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_busy) |-> cur_ptr == last_ptr);

    // R11: bounds frozen during a run
    p_bounds_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_busy && $past(run_busy)) |-> ($stable(first_ptr) && $stable(last_ptr)));
endmodule

bind qspi_master qspi_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .run_busy (run_busy),
    .done_flag(done_flag),
    .cur_ptr  (cur_ptr),
    .first_ptr(first_ptr),
    .last_ptr (last_ptr)
);

// File: tb/qspi_master_test.sv
module qspi_master_test;
    localparam int H = 4;
    localparam int D = 2;

    localparam int A_FIRST = 'h210;
    localparam int A_LAST  = 'h214;
    localparam int A_CTRL  = 'h218;
    localparam int A_STAT  = 'h220;
    localparam int A_CUR   = 'h224;
    localparam int A_LOCK  = 'h380;

    logic        clk = 0, rst_n = 0;
    logic        bus_sel = 0, bus_wr = 0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        spi_sck, spi_mosi, spi_miso;
    logic [3:0]  spi_cs_n;

    int checks = 0, bad = 0;
    bit finished = 0;

    qspi_master #(.HALF_DIV(H), .DELAY_HALVES(D), .ADDR_W(10)) uut (
        .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .spi_sck, .spi_mosi, .spi_miso, .spi_cs_n
    );

    always #10 clk = ~clk;

    // Reference queue contents
    logic [7:0] m_tx [16];
    logic [7:0] m_cmd[16];

    // Slave model, evaluated on every clock
    int         cyc = 0, bitn = 0, nbyte = 0, last_rise = 0, cs_fall = 0, period = 0;
    logic       sck_p = 0;
    logic [3:0] cs_p = 4'hF;
    logic [7:0] sh = 0;
    bit         saw_high = 1;
    logic [7:0] got_byte[$];
    logic [3:0] got_cs[$];
    bit         got_gap[$];
    int         got_dly[$];

    function automatic logic [7:0] resp_of(int n);
        return 8'(8'h5A + n * 37);
    endfunction

    assign spi_miso = resp_of(nbyte)[3'(7 - bitn)];

    always @(negedge clk) begin
        cyc++;
        if (spi_cs_n == 4'hF) saw_high = 1;
        if (cs_p == 4'hF && spi_cs_n != 4'hF) cs_fall = cyc;
        if (spi_sck && !sck_p) begin
            if (bitn == 0) begin
                got_cs.push_back(spi_cs_n);
                got_gap.push_back(saw_high);
                got_dly.push_back(cyc - cs_fall);
                saw_high = 0;
            end
            if (bitn == 1) period = cyc - last_rise;
            last_rise = cyc;
            bitn++;
            if (bitn == 8) begin
                got_byte.push_back({sh[6:0], spi_mosi});
                bitn = 0;
                nbyte++;
            end
            sh = {sh[6:0], spi_mosi};
        end
        sck_p = spi_sck;
        cs_p  = spi_cs_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = 10'(a); bus_wdata = 32'(v);
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = 10'(a);
        #1 v = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic set_entry(input int e, input logic [7:0] t, input logic [7:0] c);
        m_tx[e] = t; m_cmd[e] = c;
        wr('h240 + 8 * e, t);
        wr('h340 + 4 * e, c);
    endtask

    task automatic wait_done(input int first, input int last, input bit check_cur);
        logic [31:0] v;
        bit in_set, cur_ok = 1;
        int last_cur = 0;
        for (int i = 0; i < 4000; i++) begin
            rd(A_STAT, v);
            if (v[0]) break;
            if (check_cur) begin
                rd(A_CUR, v);
                in_set = (first <= last) ? (v >= first && v <= last)
                                         : (v >= first || v <= last);
                if (!in_set) begin cur_ok = 0; last_cur = v; end
            end
        end
        chk(v[0] == 1'b1, "R8 done flag set", v[0], 1);
        if (check_cur) chk(cur_ok, "R10 current index within run", last_cur, first);
    endtask

    task automatic run(input int first, input int last, input bit hold);
        int ents[$];
        int base = nbyte, k = first;
        logic [31:0] v;
        logic [3:0] exp_cs;
        forever begin
            ents.push_back(k);
            if (k == last) break;
            k = (k + 1) % 16;
        end
        got_byte.delete(); got_cs.delete(); got_gap.delete(); got_dly.delete();
        wr(A_FIRST, first);
        wr(A_LAST, last);
        wr(A_CTRL, 'h40 | (int'(hold) << 7));
        wait_done(first, last, 1);
        chk(got_byte.size() == ents.size(), "R4 entry count", got_byte.size(), ents.size());
        foreach (ents[j]) begin
            if (j < got_byte.size()) begin
                chk(got_byte[j] == m_tx[ents[j]], "R2 byte on MOSI", got_byte[j], m_tx[ents[j]]);
                chk(got_cs[j] == m_cmd[ents[j]][3:0], "R5 select levels", got_cs[j], m_cmd[ents[j]][3:0]);
                if (j > 0)
                    chk(got_gap[j] == !m_cmd[ents[j-1]][7], "R6 gap between entries",
                        got_gap[j], !m_cmd[ents[j-1]][7]);
            end
            rd('h2c0 + 8 * ents[j] + 4, v);
            chk(v[7:0] == resp_of(base + j), "R3 received byte", v[7:0], resp_of(base + j));
        end
        exp_cs = (m_cmd[last][7] || hold) ? m_cmd[last][3:0] : 4'hF;
        chk(spi_cs_n == exp_cs, "R7 selects after run", spi_cs_n, exp_cs);
        rd(A_CTRL, v);
        chk(v[6] == 1'b0 && v[7] == hold, "R8 go bit cleared, hold kept", v[7:6], {hold, 1'b0});
        wr(A_STAT, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk(spi_cs_n == 4'hF, "R1 selects high", spi_cs_n, 4'hF);
        chk(spi_sck == 1'b0, "R1 sck low", spi_sck, 0);
        rd(A_CTRL, v); chk(v == 0, "R1 control", v, 0);
        rd(A_STAT, v); chk(v == 0, "R1 status", v, 0);
        rd(A_CUR, v);  chk(v == 0, "R1 current index", v, 0);

        for (int e = 0; e < 16; e++)
            set_entry(e, 8'(e * 29 + 3), 8'(4'hF & ~(4'h1 << (e % 4))));

        // Single entry: R2 R3 R5 R9 R13
        run(0, 0, 0);
        chk(period == 2 * H, "R13 sck period", period, 2 * H);
        chk(got_dly.size() == 1 && got_dly[0] == H + 1, "R9 start without delay", got_dly[0], H + 1);

        // Chained entries with keep-select
        set_entry(3, 8'hA5, 8'h8E);
        set_entry(4, 8'h3C, 8'h8D);
        set_entry(5, 8'hF0, 8'h0B);
        run(3, 5, 0);

        // Gap when keep-select is clear
        set_entry(6, 8'h81, 8'h07);
        set_entry(7, 8'h7E, 8'h0E);
        run(6, 7, 0);

        // Wrap from 15 to 0 (R4)
        run(14, 1, 0);

        // R7 hold variants
        run(0, 0, 1);
        run(1, 1, 0);
        set_entry(2, 8'h55, 8'h8B);
        run(2, 2, 0);
        run(1, 1, 0);

        // R9 start delay
        set_entry(9, 8'hC3, 8'h1E);
        run(9, 9, 0);
        chk(got_dly.size() == 1 && got_dly[0] == H + 1 + D * H, "R9 delayed start",
            got_dly[0], H + 1 + D * H);

        // R11 writes during a run, R8 busy readback
        got_byte.delete();
        wr(A_FIRST, 10); wr(A_LAST, 10);
        wr(A_CTRL, 'h40);
        rd(A_CTRL, v); chk(v[6] == 1'b1, "R8 go reads 1 while busy", v[6], 1);
        wr('h240 + 80, 'hEE);
        wr('h340 + 40, 'h00);
        wr(A_FIRST, 5);
        wr(A_LAST, 12);
        wait_done(10, 10, 0);
        chk(got_byte.size() == 1 && got_byte[0] == m_tx[10], "R11 byte sent unchanged", got_byte[0], m_tx[10]);
        rd('h240 + 80, v); chk(v[7:0] == m_tx[10], "R11 tx protected", v[7:0], m_tx[10]);
        rd('h340 + 40, v); chk(v[7:0] == m_cmd[10], "R11 cmd protected", v[7:0], m_cmd[10]);
        rd(A_FIRST, v);    chk(v == 10, "R11 first index protected", v, 10);
        rd(A_LAST, v);     chk(v == 10, "R11 last index protected", v, 10);

        // R8 status clear rules
        wr(A_STAT, 1);
        rd(A_STAT, v); chk(v[0] == 1'b1, "R8 write 1 keeps done", v[0], 1);
        wr(A_STAT, 0);
        rd(A_STAT, v); chk(v[0] == 1'b0, "R8 write 0 clears done", v[0], 0);

        // R12 lock register
        wr(A_LOCK, 1);
        rd(A_LOCK, v); chk(v[0] == 1'b1, "R12 lock set", v[0], 1);
        wr(A_LOCK, 0);
        rd(A_LOCK, v); chk(v[0] == 1'b0, "R12 lock clear", v[0], 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule